// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block guards a 36-bit port split into four 9-bit lanes. The top bit of each lane carries that lane's parity. On every rising clock edge the unit checks the word on the port and registers two results: a per-lane error vector and a single active-low error flag. A single select input chooses odd or even parity. That choice applies to checking and to generation alike.

On reads, the unit can replace the parity bit of each lane with a freshly computed one before the data leaves the port. When generation is off, the read word passes through unchanged.

Each lane has one shared XOR tree. During a mailbox read with generation enabled, that tree is taken away from checking. For that case the error flag and the lane vector are forced clean at the next edge, whatever is on the port. FIFO-path reads have a small dedicated generator of their own, so checking goes on during them.

The operating mode is decoded from the direction, mailbox-select and generate-enable inputs into three named modes:
- CHECK: the tree watches the port.
- FIFO_GEN: the tree watches the port and the dedicated generator rewrites the read data.
- MAIL_GEN: the tree regenerates mailbox read data and checking is suppressed.

The mode follows the inputs in each cycle. Every mode can move to any other from one cycle to the next.

Top module: `bytepar_unit`

## Requirements
- R1: While rst_n is low, and after reset until the first checked edge, perr_n is 1 and lane_err is 4'b0000.
- R2: Lane k is bits [9k+8:9k], and bit 9k+8 is its parity bit. After a clock edge outside MAIL_GEN mode, lane_err[k] is 1 exactly when the 9 bits of lane k on bus_in had an even count of ones with odd_sel=1, or an odd count with odd_sel=0.
- R3: perr_n is registered at the same edge as lane_err. It is 0 exactly when at least one lane failed its check at that edge.
- R4: odd_sel=1 selects odd parity and odd_sel=0 selects even parity, for both checking and generation.
- R5: When wr_sel=0 and gen_en=1, each lane of rd_out keeps bits [9k+7:9k] of rd_data. Bit 9k+8 is set so that the lane's 9-bit ones count is odd when odd_sel=1 and even when odd_sel=0.
- R6: When wr_sel=1 or gen_en=0, rd_out equals rd_data, including its stored parity bits.
- R7: MAIL_GEN mode is wr_sel=0, mbox_sel=1 and gen_en=1. In that mode, the following edge leaves perr_n=1 and lane_err=0 regardless of bus_in.
- R8: FIFO_GEN mode is wr_sel=0, mbox_sel=0 and gen_en=1. In that mode, checking of bus_in continues as in R2 and R3 while rd_out carries generated parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| wr_sel | input | 1 | 1 = write cycle, 0 = read cycle |
| mbox_sel | input | 1 | 1 = mailbox path, 0 = FIFO path |
| gen_en | input | 1 | Enables parity regeneration on reads |
| bus_in | input | 36 | Word present on the port, checked each edge |
| rd_data | input | 36 | Word being read out (FIFO or mailbox) |
| rd_out | output | 36 | Read word, with regenerated parity when enabled |
| lane_err | output | 4 | Registered per-lane parity error bits |
| perr_n | output | 1 | Registered active-low parity error flag |

## Verification
Several internal faults each show up at the ports:
- A wrong parity tree or a reversed odd/even sense shows on rd_out in the same cycle.
- The same faults show on lane_err one edge later.
- A mis-decoded mode shows within one edge. Either the flag is forced in a FIFO read, so an error planted on bus_in goes missing, or the flag is not forced during a mailbox generate read, so a spurious error appears.
- A wrong lane-boundary mapping shows as an error bit in the wrong lane position as soon as a single-lane fault is injected.

// File: rtl/bytepar_pkg.sv
package bytepar_pkg;
    typedef enum logic [1:0] {
        MODE_CHECK    = 2'd0,
        MODE_FIFO_GEN = 2'd1,
        MODE_MAIL_GEN = 2'd2
    } tree_mode_e;
endpackage

// File: rtl/bytepar_mode_dec.sv
module bytepar_mode_dec
    import bytepar_pkg::*;
(
    input  logic       wr_sel,
    input  logic       mbox_sel,
    input  logic       gen_en,
    output tree_mode_e mode
);
    always_comb begin
        if (!wr_sel && gen_en && mbox_sel)
            mode = MODE_MAIL_GEN;
        else if (!wr_sel && gen_en)
            mode = MODE_FIFO_GEN;
        else
            mode = MODE_CHECK;
    end
endmodule

// File: rtl/bytepar_lane.sv
module bytepar_lane #(
    parameter int LANE_W = 9
) (
    input  logic              odd_sel,
    input  logic              gen_fifo,
    input  logic              gen_mail,
    input  logic [LANE_W-1:0] tree_in,
    input  logic [LANE_W-1:0] rd_lane,
    output logic              chk_err,
    output logic [LANE_W-1:0] rd_lane_out
);
    localparam int DW = LANE_W - 1;

    logic tree_x;
    logic fifo_x;

    // shared tree: checks the port, or regenerates mailbox data
    assign tree_x  = ^tree_in[DW-1:0];
    assign fifo_x  = ^rd_lane[DW-1:0];
    assign chk_err = tree_x ^ tree_in[DW] ^ odd_sel;

    always_comb begin
        rd_lane_out = rd_lane;
        if (gen_mail)
            rd_lane_out[DW] = tree_x ^ odd_sel;
        else if (gen_fifo)
            rd_lane_out[DW] = fifo_x ^ odd_sel;
    end
endmodule

// File: rtl/bytepar_flag_reg.sv
module bytepar_flag_reg #(
    parameter int NUM_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 force_clean,
    input  logic [NUM_BYTES-1:0] err_d,
    output logic [NUM_BYTES-1:0] lane_err_q,
    output logic                 perr_n_q
);
    logic [NUM_BYTES-1:0] err_next;
    logic                 perr_n_next;

    always_comb begin
        err_next    = force_clean ? '0 : err_d;
        perr_n_next = force_clean ? 1'b1 : ~(|err_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_err_q <= '0;
            perr_n_q   <= 1'b1;
        end else begin
            lane_err_q <= err_next;
            perr_n_q   <= perr_n_next;
        end
    end
endmodule

// File: rtl/bytepar_unit.sv
module bytepar_unit
    import bytepar_pkg::*;
#(
    parameter int NUM_BYTES = 4,
    parameter int LANE_W    = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          odd_sel,
    input  logic                          wr_sel,
    input  logic                          mbox_sel,
    input  logic                          gen_en,
    input  logic [NUM_BYTES*LANE_W-1:0]   bus_in,
    input  logic [NUM_BYTES*LANE_W-1:0]   rd_data,
    output logic [NUM_BYTES*LANE_W-1:0]   rd_out,
    output logic [NUM_BYTES-1:0]          lane_err,
    output logic                          perr_n
);
    localparam int DATA_W = NUM_BYTES * LANE_W;

    tree_mode_e          mode;
    logic                gen_fifo;
    logic                gen_mail;
    logic [NUM_BYTES-1:0] err_comb;
    logic [DATA_W-1:0]   tree_src;

    bytepar_mode_dec u_dec (
        .wr_sel   (wr_sel),
        .mbox_sel (mbox_sel),
        .gen_en   (gen_en),
        .mode     (mode)
    );

    always_comb begin
        gen_fifo = 1'b0;
        gen_mail = 1'b0;
        unique case (mode)
            MODE_CHECK:    ;
            MODE_FIFO_GEN: gen_fifo = 1'b1;
            MODE_MAIL_GEN: gen_mail = 1'b1;
            default:       ;
        endcase
    end

    assign tree_src = gen_mail ? rd_data : bus_in;

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
        bytepar_lane #(.LANE_W(LANE_W)) u_lane (
            .odd_sel     (odd_sel),
            .gen_fifo    (gen_fifo),
            .gen_mail    (gen_mail),
            .tree_in     (tree_src[k*LANE_W +: LANE_W]),
            .rd_lane     (rd_data[k*LANE_W +: LANE_W]),
            .chk_err     (err_comb[k]),
            .rd_lane_out (rd_out[k*LANE_W +: LANE_W])
        );
    end

    bytepar_flag_reg #(.NUM_BYTES(NUM_BYTES)) u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_clean (gen_mail),
        .err_d       (err_comb),
        .lane_err_q  (lane_err),
        .perr_n_q    (perr_n)
    );
endmodule

// File: rtl/bytepar_unit_chk.sv
module bytepar_unit_chk #(
    parameter int NUM_BYTES = 4,
    parameter int LANE_W    = 9
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        odd_sel,
    input logic                        wr_sel,
    input logic                        mbox_sel,
    input logic                        gen_en,
    input logic [NUM_BYTES*LANE_W-1:0] bus_in,
    input logic [NUM_BYTES*LANE_W-1:0] rd_data,
    input logic [NUM_BYTES*LANE_W-1:0] rd_out,
    input logic [NUM_BYTES-1:0]        lane_err,
    input logic                        perr_n
);
    localparam int DATA_W = NUM_BYTES * LANE_W;

    function automatic logic [NUM_BYTES-1:0] ref_err(input logic [DATA_W-1:0] w, input logic odd);
        for (int k = 0; k < NUM_BYTES; k++)
            ref_err[k] = (^w[k*LANE_W +: LANE_W]) ^ odd;
    endfunction

    function automatic logic gen_ok(input logic [DATA_W-1:0] src, input logic [DATA_W-1:0] o, input logic odd);
        gen_ok = 1'b1;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (o[k*LANE_W +: LANE_W-1] != src[k*LANE_W +: LANE_W-1]) gen_ok = 1'b0;
            if ((^o[k*LANE_W +: LANE_W]) != odd) gen_ok = 1'b0;
        end
    endfunction

    logic mail_gen;
    assign mail_gen = !wr_sel && mbox_sel && gen_en;

    AST_FLAG_TRACKS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        perr_n == ~(|lane_err)); // R3

    AST_CHECK_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !mail_gen |=> lane_err == ref_err($past(bus_in), $past(odd_sel))); // R2

    AST_MAIL_GEN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        mail_gen |=> (perr_n && lane_err == '0)); // R7

    AST_GEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_sel && gen_en) |-> gen_ok(rd_data, rd_out, odd_sel)); // R5

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel || !gen_en) |-> rd_out == rd_data); // R6
endmodule

bind bytepar_unit bytepar_unit_chk #(.NUM_BYTES(NUM_BYTES), .LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .wr_sel(wr_sel), .mbox_sel(mbox_sel),
    .gen_en(gen_en), .bus_in(bus_in), .rd_data(rd_data), .rd_out(rd_out),
    .lane_err(lane_err), .perr_n(perr_n)
);

// File: tb/bytepar_unit_test.sv
`timescale 1ns/1ps
module bytepar_unit_test;
    localparam int NB = 4;
    localparam int LW = 9;
    localparam int DW = NB * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          odd_sel = 1'b0, wr_sel = 1'b1, mbox_sel = 1'b0, gen_en = 1'b0;
    logic [DW-1:0] bus_in = '0, rd_data = '0;
    logic [DW-1:0] rd_out;
    logic [NB-1:0] lane_err;
    logic          perr_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bytepar_unit uut (
        .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .wr_sel(wr_sel),
        .mbox_sel(mbox_sel), .gen_en(gen_en), .bus_in(bus_in), .rd_data(rd_data),
        .rd_out(rd_out), .lane_err(lane_err), .perr_n(perr_n)
    );

    function automatic logic [NB-1:0] exp_err(input logic [DW-1:0] w, input logic odd);
        for (int k = 0; k < NB; k++)
            exp_err[k] = (^w[k*LW +: LW]) ^ odd;
    endfunction

    function automatic logic [DW-1:0] exp_gen(input logic [DW-1:0] w, input logic odd);
        exp_gen = w;
        for (int k = 0; k < NB; k++)
            exp_gen[k*LW + LW - 1] = (^w[k*LW +: LW-1]) ^ odd;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // called at a negedge: drive, check comb output, then check registered flags
    task automatic run_vec(input logic odd, input logic wr, input logic mb, input logic ge,
                           input logic [DW-1:0] b, input logic [DW-1:0] r);
        logic          mail;
        logic [NB-1:0] e_err;
        logic [DW-1:0] e_out;
        odd_sel = odd; wr_sel = wr; mbox_sel = mb; gen_en = ge; bus_in = b; rd_data = r;
        mail  = !wr && mb && ge;
        e_out = (!wr && ge) ? exp_gen(r, odd) : r;
        e_err = mail ? '0 : exp_err(b, odd);
        #1;
        check((!wr && ge) ? "R5 generated read" : "R6 pass-through", rd_out, e_out);
        @(negedge clk);
        check(mail ? "R7 lane_err forced" : "R2 lane_err", {{(DW-NB){1'b0}}, lane_err}, {{(DW-NB){1'b0}}, e_err});
        check(mail ? "R7 perr_n forced" : "R3 perr_n", {{(DW-1){1'b0}}, perr_n}, {{(DW-1){1'b0}}, ~(|e_err)});
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        #100000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] good;
        void'($urandom(32'h1bad5eed));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset perr_n", {{(DW-1){1'b0}}, perr_n}, {{(DW-1){1'b0}}, 1'b1});
        check("R1 reset lane_err", {{(DW-NB){1'b0}}, lane_err}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset perr_n", {{(DW-1){1'b0}}, perr_n}, {{(DW-1){1'b0}}, 1'b1});

        // R4: all-zero word fails odd, passes even
        run_vec(1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
        run_vec(1'b0, 1'b1, 1'b0, 1'b0, '0, '0);
        // R2: single-lane fault at lane 2 in even mode
        run_vec(1'b0, 1'b1, 1'b0, 1'b0, 36'h1 << 18, '0);
        // R2: parity bit of lane 3 alone
        run_vec(1'b0, 1'b1, 1'b0, 1'b0, 36'h1 << 35, '0);
        // R7: mailbox generate read with bad bus
        run_vec(1'b1, 1'b0, 1'b1, 1'b1, '0, 36'h0_1234_5678);
        // R8: FIFO generate read still checks bus
        run_vec(1'b1, 1'b0, 1'b0, 1'b1, '0, 36'hF_0F0F_0F0F);
        // R6: read without generation keeps stored parity bits
        run_vec(1'b1, 1'b0, 1'b1, 1'b0, 36'h1 << 9, 36'h8_0402_0100);
        // R4: generation with even parity
        run_vec(1'b0, 1'b0, 1'b0, 1'b1, '0, 36'hF_FFFF_FFFF);
        // R8: clean bus during FIFO generate read leaves flag high
        good = exp_gen(rnd_word(), 1'b1);
        run_vec(1'b1, 1'b0, 1'b0, 1'b1, good, rnd_word());

        for (int i = 0; i < 300; i++) begin
            logic [3:0] r = 4'($urandom());
            logic [DW-1:0] b = rnd_word();
            if (r[3] && r[2]) b = exp_gen(b, r[0]);
            run_vec(r[0], r[1], r[2], r[3] | r[1] ? r[3] : 1'b1, b, rnd_word());
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule